// File: doc/BRIEF.md
# Serial Character Transmitter with Parity and Break Control

This block turns bytes written by a CPU into asynchronous serial frames on a single TX line. A one-byte holding register takes each write, and a shift register sends the held character. Each frame carries a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. Bit timing comes from an enable input that pulses at sixteen times the baud rate. The block has no divisor of its own.

The parity bit can be odd, even, or forced to a constant ("stick" parity). Word length, stop count and parity settings are captured when a character moves into the shifter. A break control holds the line low for as long as it is set. Two flags go back to the CPU. One shows that the holding register can take a byte. The other shows that both the holding register and the shifter are empty.

The sequencer has five states. IDLE goes to START when the holding register is full, and the byte is taken in that same cycle. START goes to DATA after one bit time. DATA goes to PARITY after the last configured data bit if parity is on, and to STOP if it is off. PARITY goes to STOP after one bit time. STOP returns to IDLE after the last stop bit ends.

Top module: `serial_tx`

## Requirements
- R1: After reset, `tx_out` is 1 and both `thr_empty` and `tx_empty` are 1.
- R2: A frame is one 0 start bit, then the data bits with the LSB first, then the stop bits at 1. The data bit count is 5 + `cfg_wlen` (00 gives 5, 11 gives 8). `cfg_two_stop`=1 selects two stop bits and 0 selects one.
- R3: Each bit lasts exactly 16 cycles in which `baud_tick` is 1. Cycles with `baud_tick` at 0 do not advance the frame.
- R4: When `cfg_par_en`=0, no parity bit is sent, whatever `cfg_par_even` and `cfg_par_stick` hold.
- R5: When `cfg_par_en`=1 and `cfg_par_stick`=0, a parity bit follows the data bits. It is computed over the configured data bits only. `cfg_par_even`=1 makes the count of ones even, and 0 makes it odd.
- R6: When `cfg_par_en`=1 and `cfg_par_stick`=1, the parity bit is the constant 1 if `cfg_par_even`=0, and the constant 0 if `cfg_par_even`=1.
- R7: From the clock edge after `cfg_break` is seen at 1, `tx_out` is 0, whether or not a frame is in progress. It stays 0 until `cfg_break` is cleared. One edge after clearing, `tx_out` follows the frame again.
- R8: `thr_empty` falls at the edge that captures a write. It rises at the edge where the held byte moves into the shifter. A byte written during a frame stays held until that frame's last stop bit has ended.
- R9: `tx_empty` is 1 only when the holding register is empty and no frame is in progress.
- R10: A held character is loaded only after the previous frame's last stop bit has fully elapsed. Consecutive held characters go out in write order.
- R11: A write while the holding register is full replaces the held byte. The overwritten byte is never sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle enable at 16x the baud rate |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| cfg_wlen | input | 2 | Data bits minus 5 |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| cfg_par_en | input | 1 | 1 = send a parity bit |
| cfg_par_even | input | 1 | Parity type: 1 = even (or forced 0) |
| cfg_par_stick | input | 1 | 1 = parity bit is a constant |
| cfg_break | input | 1 | 1 = hold TX low |
| tx_out | output | 1 | Serial line, idles at 1 |
| thr_empty | output | 1 | Holding register empty |
| tx_empty | output | 1 | Holding register and shifter both empty |

## Verification
A bit counter that is off by one, or a wrong state transition, shows up on `tx_out` as a misplaced or missing bit. This is seen at the centre of the first wrong bit, within 16 ticks of the fault. The bench sweeps every word length, stop count and parity setting combination, at several tick densities. A slip in how ticks are counted shifts every later sample, so it cannot hide. A holding-register fault is seen within one cycle of a write on `thr_empty`, or as a lost or duplicated character in the next frame.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_t;
endpackage

// File: rtl/serial_tx_hold.sv
module serial_tx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic [DATA_W-1:0] hold_data,
    output logic              hold_full
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_full <= 1'b0;
            hold_data <= '0;
        end else begin
            if (wr_en) begin
                hold_data <= wr_data;
                hold_full <= 1'b1;
            end else if (take) begin
                hold_full <= 1'b0;
            end
        end
    end

    // R8
    write_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> hold_full);
endmodule

// File: rtl/serial_tx_parity.sv
module serial_tx_parity #(
    parameter int DATA_W = 8,
    parameter int LEN_W  = 2
) (
    input  logic [DATA_W-1:0] data,
    input  logic [LEN_W-1:0]  wlen,
    input  logic              par_even,
    input  logic              par_stick,
    output logic              par_bit
);
    localparam int MIN_W = DATA_W - (1 << LEN_W) + 1;

    logic [DATA_W-1:0] mask;
    logic              ones_odd;

    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign mask[i] = (32'(i) < (32'(MIN_W) + 32'(wlen)));
    end

    assign ones_odd = ^(data & mask);

    always_comb begin
        if (par_stick) par_bit = !par_even;
        else if (par_even) par_bit = ones_odd;
        else par_bit = !ones_odd;
    end
endmodule

// File: rtl/serial_tx_fsm.sv
module serial_tx_fsm
    import serial_tx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int LEN_W      = 2,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    input  logic [LEN_W-1:0]  cfg_wlen,
    input  logic              cfg_two_stop,
    input  logic              cfg_par_en,
    input  logic              cfg_par_even,
    input  logic              cfg_par_stick,
    output logic              take,
    output logic              line_bit,
    output logic              busy
);
    localparam int MIN_W  = DATA_W - (1 << LEN_W) + 1;
    localparam int TICK_W = $clog2(OVERSAMPLE);
    localparam int IDX_W  = $clog2(DATA_W);

    tx_state_t         state_q, state_d;
    logic [TICK_W-1:0] tick_q;
    logic [IDX_W-1:0]  idx_q, last_q;
    logic [DATA_W-1:0] shreg_q;
    logic              par_q, par_en_q, two_stop_q, par_calc, bit_end;

    serial_tx_parity #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_parity (
        .data      (hold_data),
        .wlen      (cfg_wlen),
        .par_even  (cfg_par_even),
        .par_stick (cfg_par_stick),
        .par_bit   (par_calc)
    );

    assign bit_end = baud_tick && (tick_q == TICK_W'(OVERSAMPLE - 1));
    assign take    = (state_q == ST_IDLE) && hold_full;
    assign busy    = (state_q != ST_IDLE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (hold_full) state_d = ST_START;
            ST_START:  if (bit_end) state_d = ST_DATA;
            ST_DATA:   if (bit_end && idx_q == last_q)
                           state_d = par_en_q ? ST_PARITY : ST_STOP;
            ST_PARITY: if (bit_end) state_d = ST_STOP;
            ST_STOP:   if (bit_end && idx_q == IDX_W'(two_stop_q))
                           state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            tick_q     <= '0;
            idx_q      <= '0;
            last_q     <= '0;
            shreg_q    <= '0;
            par_q      <= 1'b0;
            par_en_q   <= 1'b0;
            two_stop_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE) tick_q <= '0;
            else if (bit_end) tick_q <= '0;
            else if (baud_tick) tick_q <= tick_q + 1'b1;
            if (state_d != state_q) idx_q <= '0;
            else if (bit_end) idx_q <= idx_q + 1'b1;
            if (take) begin
                shreg_q    <= hold_data;
                par_q      <= par_calc;
                par_en_q   <= cfg_par_en;
                two_stop_q <= cfg_two_stop;
                last_q     <= IDX_W'(MIN_W - 1 + int'(cfg_wlen));
            end else if (state_q == ST_DATA && bit_end) begin
                shreg_q <= shreg_q >> 1;
            end
        end
    end

    // output logic
    always_comb begin
        unique case (state_q)
            ST_IDLE:   line_bit = 1'b1;
            ST_START:  line_bit = 1'b0;
            ST_DATA:   line_bit = shreg_q[0];
            ST_PARITY: line_bit = par_q;
            ST_STOP:   line_bit = 1'b1;
            default:   line_bit = 1'b1;
        endcase
    end

    // R3
    tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!baud_tick && state_q != ST_IDLE) |=> $stable(tick_q));

    // R10
    load_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_START && $past(state_q) != ST_START) |-> $past(state_q) == ST_IDLE);
endmodule

// File: rtl/serial_tx.sv
module serial_tx #(
    parameter int DATA_W     = 8,
    parameter int LEN_W      = 2,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LEN_W-1:0]  cfg_wlen,
    input  logic              cfg_two_stop,
    input  logic              cfg_par_en,
    input  logic              cfg_par_even,
    input  logic              cfg_par_stick,
    input  logic              cfg_break,
    output logic              tx_out,
    output logic              thr_empty,
    output logic              tx_empty
);
    logic [DATA_W-1:0] hold_data;
    logic              hold_full, take, line_bit, busy;

    serial_tx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .take      (take),
        .hold_data (hold_data),
        .hold_full (hold_full)
    );

    serial_tx_fsm #(.DATA_W(DATA_W), .LEN_W(LEN_W), .OVERSAMPLE(OVERSAMPLE)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .baud_tick     (baud_tick),
        .hold_full     (hold_full),
        .hold_data     (hold_data),
        .cfg_wlen      (cfg_wlen),
        .cfg_two_stop  (cfg_two_stop),
        .cfg_par_en    (cfg_par_en),
        .cfg_par_even  (cfg_par_even),
        .cfg_par_stick (cfg_par_stick),
        .take          (take),
        .line_bit      (line_bit),
        .busy          (busy)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_out <= 1'b1;
        else        tx_out <= cfg_break ? 1'b0 : line_bit;
    end

    assign thr_empty = !hold_full;
    assign tx_empty  = !hold_full && !busy;

    // R7
    break_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_break |=> !tx_out);

    // R9
    empty_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> thr_empty);

    // R8
    thr_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(thr_empty) |-> $past(wr_en));
endmodule

// File: tb/serial_tx_bench.sv
module serial_tx_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] cfg_wlen = 2'b11;
    logic       cfg_two_stop = 1'b0;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_even = 1'b0;
    logic       cfg_par_stick = 1'b0;
    logic       cfg_break = 1'b0;
    logic       tx_out, thr_empty, tx_empty;

    int n_checks = 0;
    int n_fail = 0;
    int tick_div = 1;
    int tick_cnt = 0;
    bit done = 0;

    always #2 clk = ~clk;

    serial_tx u_serial_tx (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
        .wr_en(wr_en), .wr_data(wr_data), .cfg_wlen(cfg_wlen),
        .cfg_two_stop(cfg_two_stop), .cfg_par_en(cfg_par_en),
        .cfg_par_even(cfg_par_even), .cfg_par_stick(cfg_par_stick),
        .cfg_break(cfg_break), .tx_out(tx_out),
        .thr_empty(thr_empty), .tx_empty(tx_empty)
    );

    always @(negedge clk) begin
        if (tick_cnt + 1 >= tick_div) tick_cnt <= 0;
        else tick_cnt <= tick_cnt + 1;
        baud_tick <= (tick_cnt + 1 >= tick_div);
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_ticks(input int n);
        for (int k = 0; k < n; k++) begin
            do @(posedge clk); while (!baud_tick);
        end
        @(negedge clk);
    endtask

    task automatic write_byte(input logic [7:0] d);
        wr_data = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic check_frame(input logic [7:0] d, input int wl, input bit two,
                               input bit pen, input bit peven, input bit pstick);
        int guard = 0;
        int nbits = 5 + wl;
        bit x = 1'b0;
        bit pexp;
        while (tx_out !== 1'b0 && guard < 4000) begin
            @(negedge clk);
            guard++;
        end
        wait_ticks(8);
        chk("R2 start", int'(tx_out), 0);
        for (int b = 0; b < nbits; b++) begin
            wait_ticks(16);
            chk("R2 data", int'(tx_out), int'(d[b]));
            x ^= d[b];
        end
        if (pen) begin
            pexp = pstick ? !peven : (peven ? x : !x);
            wait_ticks(16);
            chk(pstick ? "R6 stick parity" : "R5 parity", int'(tx_out), int'(pexp));
        end
        wait_ticks(16);
        chk(pen ? "R2 stop" : "R4 stop follows data", int'(tx_out), 1);
        if (two) begin
            wait_ticks(16);
            chk("R2 second stop", int'(tx_out), 1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1
        chk("R1 tx idle", int'(tx_out), 1);
        chk("R1 thr_empty", int'(thr_empty), 1);
        chk("R1 tx_empty", int'(tx_empty), 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 / R9 flag timing with an idle transmitter
        write_byte(8'hA5);
        chk("R8 thr falls on write", int'(thr_empty), 0);
        chk("R9 tx_empty low", int'(tx_empty), 0);
        @(negedge clk);
        chk("R8 thr rises on load", int'(thr_empty), 1);
        chk("R9 tx_empty while shifting", int'(tx_empty), 0);
        check_frame(8'hA5, 3, 0, 0, 0, 0);
        wait_ticks(16);
        chk("R9 thr_empty after frame", int'(thr_empty), 1);
        chk("R9 tx_empty after frame", int'(tx_empty), 1);

        // R10 / R11 back-to-back with overwrite
        write_byte(8'h3C);
        write_byte(8'h81);
        write_byte(8'h5E);
        chk("R8 held during frame", int'(thr_empty), 0);
        check_frame(8'h3C, 3, 0, 0, 0, 0);
        chk("R8 still held in stop", int'(thr_empty), 0);
        check_frame(8'h5E, 3, 0, 0, 0, 0);   // R11: 0x81 dropped, R10 order
        wait_ticks(16);
        chk("R10 idle after queue", int'(tx_empty), 1);

        // sweep: R2 R3 R4 R5 R6
        for (int combo = 0; combo < 64; combo++) begin
            for (int v = 0; v < 2; v++) begin
                logic [7:0] d;
                d = 8'(combo * 29 + 7);
                if (v == 1) d = ~d;
                tick_div = 1 + (combo % 3);
                cfg_wlen      = 2'(combo & 3);
                cfg_two_stop  = combo[2];
                cfg_par_en    = combo[3];
                cfg_par_even  = combo[4];
                cfg_par_stick = combo[5];
                write_byte(d);
                check_frame(d, combo & 3, combo[2], combo[3], combo[4], combo[5]);
            end
        end
        tick_div = 1;
        wait_ticks(24);
        chk("R9 thr_empty after sweep", int'(thr_empty), 1);
        chk("R9 tx_empty after sweep", int'(tx_empty), 1);

        // R7 break
        cfg_wlen = 2'b11; cfg_two_stop = 0; cfg_par_en = 0;
        cfg_break = 1'b1;
        @(negedge clk);
        chk("R7 break idle", int'(tx_out), 0);
        write_byte(8'hFF);
        repeat (40) @(negedge clk);
        chk("R7 break during frame", int'(tx_out), 0);
        chk("R9 busy under break", int'(tx_empty), 0);
        cfg_break = 1'b0;
        @(negedge clk);
        chk("R7 release shows data bit", int'(tx_out), 1);
        begin
            int g = 0;
            while (!tx_empty && g < 1000) begin
                @(negedge clk);
                g++;
            end
        end
        chk("R9 empty after break frame", int'(tx_empty), 1);
        chk("R7 line idle", int'(tx_out), 1);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule